// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes in stereo PCM audio over a three-wire serial link: a bit clock, a word clock that marks the left and right halves of each frame, and a data line. It recovers one 18-bit two's-complement sample per channel per frame. A static format input chooses how the word sits inside each half-frame. In right-justified mode the word ends at the word clock transition. In I2S mode the word starts one bit clock after that transition.

All three link wires pass through two-flop synchronisers into the system clock domain. The system clock must run at least 256 times the sample rate. Bit-clock rising edges are detected there, and the data line is sampled at each of them. Once the right-channel word of a frame has completed, the receiver presents the finished left/right pair together with a single-cycle valid strobe.

Top module: `serial_pcm_rx`

## Requirements
- R1: While reset is asserted and after its release, until the first pair is delivered, `left_o` and `right_o` read zero and `valid_o` is low.
- R2: With `fmt_i2s` low (right-justified), the word of a half-frame is the last W bits sampled before the word clock changes, MSB first. Any earlier bits in that half-frame are ignored.
- R3: With `fmt_i2s` high (I2S), the bit sampled on the first rising bit clock after a word clock change is ignored. The next W bits form the word, MSB first. Any further bits before the next change are ignored.
- R4: In right-justified mode the left channel is the half-frame with `ws` high. In I2S mode the left channel is the half-frame with `ws` low.
- R5: `valid_o` pulses for exactly one system clock per frame. This happens after the word clock change that ends the right-channel half-frame. `left_o` and `right_o` change only in that cycle and hold their values between pulses.
- R6: `sd` is sampled only on rising edges of `sck`. A change of `sd` while `sck` is low or high does not alter the captured bits.
- R7: A pair is delivered only if its left word came from a half-frame that began with an observed word clock change after reset. A partial half-frame seen after reset therefore produces no output.
- R8: The sample value passes through unchanged across the full two's-complement range, including the most negative and most positive codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 256 times the sample rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_i2s | input | 1 | Static format select: 0 right-justified, 1 I2S |
| sck | input | 1 | Serial bit clock, asynchronous to clk |
| ws | input | 1 | Word (left/right) clock at the sample rate |
| sd | input | 1 | Serial data, MSB first |
| left_o | output | W (18) | Left-channel sample |
| right_o | output | W (18) | Right-channel sample |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The bench builds the receiver with its default word width W = 18. It drives bit clocks of 8 system clocks per period, so every synchroniser and edge detector runs at a realistic oversampling ratio. Half-frames of 18, 24 and 32 bit clocks in right-justified mode, and of 19, 24 and 32 in I2S mode, exercise the exact-fit cases and the padded cases. In the padded cases random filler bits must be discarded. Each run opens with a partial half-frame to show that start-up debris is not delivered, and includes the extreme codes 0x1FFFF and 0x20000.

// File: rtl/serial_pcm_rx.sv
module serial_pcm_rx #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fmt_i2s,
  input  logic         sck,
  input  logic         ws,
  input  logic         sd,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);
  localparam int CW = $clog2(W + 1);

  logic [2:0]    sck_q;
  logic [1:0]    ws_q, sd_q;
  logic          ws_prev, primed, seen, lvalid;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sreg, lhold;

  wire rise      = sck_q[1] & ~sck_q[2];
  wire ws_s      = ws_q[1];
  wire sd_s      = sd_q[1];
  wire ws_edge   = primed && (ws_s != ws_prev);
  wire left_done = ws_prev ^ fmt_i2s;
  wire room      = cnt < CW'(W);
  wire [W-1:0] shifted = {sreg[W-2:0], sd_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      ws_q  <= '0;
      sd_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      ws_q  <= {ws_q[0], ws};
      sd_q  <= {sd_q[0], sd};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev <= 1'b0;
      primed  <= 1'b0;
      seen    <= 1'b0;
      lvalid  <= 1'b0;
      cnt     <= '0;
      sreg    <= '0;
      lhold   <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise) begin
        primed  <= 1'b1;
        ws_prev <= ws_s;
        if (ws_edge) begin
          cnt  <= '0;
          seen <= 1'b1;
          if (!fmt_i2s) sreg <= shifted;
          if (left_done) begin
            lhold  <= sreg;
            lvalid <= seen;
          end else begin
            if (lvalid) begin
              left_o  <= lhold;
              right_o <= sreg;
              valid_o <= 1'b1;
            end
            lvalid <= 1'b0;
          end
        end else begin
          if (!fmt_i2s || room) sreg <= shifted;
          if (room) cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

module serial_pcm_rx_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fmt_i2s,
  input logic         ws_prev,
  input logic         lvalid,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         valid_o
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);                                          // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({left_o, right_o}) |-> valid_o);                       // R5
  AST_LEFT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(lvalid));                              // R7
  AST_RIGHT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (ws_prev != fmt_i2s));                              // R4
endmodule

bind serial_pcm_rx serial_pcm_rx_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .ws_prev(ws_prev),
  .lvalid(lvalid), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
);

// File: tb/serial_pcm_rx_tb.sv
module serial_pcm_rx_tb;
  localparam int W = 18;
  localparam time CLK_PERIOD = 10ns;
  localparam int HB = 4;

  logic clk = 1'b0, rst_n = 1'b0, fmt_i2s = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [W-1:0] left_o, right_o;
  logic valid_o;

  int checks = 0, fails = 0, sent = 0, got = 0;
  bit done = 0, prev_valid = 0;
  logic [W-1:0] exp_l[$], exp_r[$];

  serial_pcm_rx #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .sck(sck), .ws(ws), .sd(sd),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic slot_bit(input logic f, input int n, input int i, input logic [W-1:0] word);
    if (!f) return (i >= n - W) ? word[W-1-(i-(n-W))] : 1'($urandom);
    return (i >= 1 && i <= W) ? word[W-i] : 1'($urandom);
  endfunction

  task automatic bit_out(input logic w, input logic d);
    @(negedge clk); sck = 1'b0; ws = w; sd = d;
    repeat (HB - 1) @(negedge clk);
    sd = ~d;               // R6: toggle mid-low, restored before rise
    @(negedge clk); sd = d; sck = 1'b1;
    repeat (HB - 1) @(negedge clk);
    sd = 1'($urandom);     // R6: change while high
  endtask

  task automatic send_half(input logic w, input int n, input logic [W-1:0] word);
    for (int i = 0; i < n; i++) bit_out(w, slot_bit(fmt_i2s, n, i, word));
  endtask

  task automatic send_frame(input int n, input logic [W-1:0] l, input logic [W-1:0] r);
    logic lw;
    lw = fmt_i2s ? 1'b0 : 1'b1;
    exp_l.push_back(l); exp_r.push_back(r); sent++;
    send_half(lw, n, l);
    send_half(~lw, n, r);
  endtask

  task automatic run(input logic f, input int n, input int nrand);
    logic lw;
    rst_n = 1'b0; fmt_i2s = f; sck = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 left in reset", left_o, '0);
    check("R1 right in reset", right_o, '0);
    check("R1 valid in reset", {{(W-1){1'b0}}, valid_o}, '0);
    rst_n = 1'b1;
    lw = f ? 1'b0 : 1'b1;
    send_half(lw, 5, W'($urandom));      // R7 partial half-frame
    send_half(~lw, n, W'($urandom));
    check("R1 idle after reset", left_o, '0);
    send_frame(n, 18'h1FFFF, 18'h20000); // R8 extremes
    send_frame(n, 18'h00000, 18'h3FFFF);
    send_frame(n, 18'h2AAAA, 18'h15555);
    for (int k = 0; k < nrand; k++) send_frame(n, W'($urandom), W'($urandom));
    send_half(lw, n, W'($urandom));
    repeat (20) @(negedge clk);
    checks++;
    if (exp_l.size() != 0) begin
      fails++;
      $display("FAIL R5 pairs pending actual=%0d expected=0", exp_l.size());
    end
    exp_l.delete(); exp_r.delete();
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      got++;
      checks++;
      if (prev_valid) begin
        fails++;
        $display("FAIL R5 strobe width actual=2+ expected=1");
      end
      if (exp_l.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected pair actual=%h/%h expected=none", left_o, right_o);
      end else begin
        check(fmt_i2s ? "R3/R4 left" : "R2/R4 left", left_o, exp_l.pop_front());
        check(fmt_i2s ? "R3/R4 right" : "R2/R4 right", right_o, exp_r.pop_front());
      end
    end
    prev_valid = valid_o;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    run(1'b0, 32, 6);
    run(1'b0, 24, 5);
    run(1'b0, 18, 5);
    run(1'b1, 32, 6);
    run(1'b1, 19, 5);
    run(1'b1, 24, 5);
    checks++;
    if (got != sent) begin
      fails++;
      $display("FAIL R5 pair count actual=%0d expected=%0d", got, sent);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule